// File: doc/BRIEF.md
# Operating-State Controller for Reset, Low-Power and Emulation Modes

This block decides in which operating state a small microcontroller core sits and derives from that state every clock gate and every pin-ownership code. It qualifies the external reset pin over a fixed number of machine cycles and holds the core in internal reset while the pin stays high. It also carries out software requests for idle and power-down, and wakes from idle on a pending interrupt. Power-down ends on a level-type external interrupt whose pin is pulled low. A programmable oscillator settling count then runs before the core clock returns. The block also recognises entry into an emulation mode, in which the device lets go of its pins so that an outside tester can drive the board.

The block itself runs on an always-present reference clock. The oscillator, the core and the peripherals are controlled only through enables. The core's interrupt controller supplies an "any enabled interrupt pending" flag and the enable and trigger-type bits of the two external interrupts. The pad ring takes a two-bit code per pin group: 0 = normal function, 1 = driven low, 2 = driven high, 3 = driver released (port 0 floats, other pins keep only their weak pull-up).

Top module: `pwr_mode_ctrl`

## Requirements
- R1: With the oscillator settled, `int_rst` rises on the (K+1)th rising clock edge after `rst_pin` is first sampled high, where K = 2 × CYC_PER_MC. If `rst_pin` is high for fewer than K sampled edges, it has no effect on `int_rst`.
- R2: After `rst_pin` is sampled low, `int_rst` falls on the second rising edge, and the core clock enable is then high.
- R3: `idle_req` in the run state stops the core clock one edge later while the peripheral clock and the oscillator stay on. In idle, `irq_pend` restores the core clock one edge later.
- R4: `pd_req` in the run state turns off the oscillator, the core clock and the peripheral clock one edge later. When `idle_req` and `pd_req` arrive in the same cycle, power-down is taken.
- R5: In power-down, a low level on an external interrupt pin does not wake the oscillator unless that interrupt is both enabled and set to level mode (`intX_en`=1 and `intX_level`=1).
- R6: In power-down, a qualified interrupt pin sampled low raises `osc_en` one edge later. If the pin is already high again, `core_clk_en` rises STABLE+2 edges after `osc_en` rises, where STABLE is the value on `stable_cnt`.
- R7: While the waking pin is still held low after the settling count has expired, the core clock stays off. It turns on one edge after the pin is sampled high.
- R8: `rst_pin` high in power-down restarts the oscillator one edge later. Reset qualification then begins once the settling count has expired, so `int_rst` rises STABLE+K+3 edges after the first edge that sampled `rst_pin` high.
- R9: Emulation mode (`emu_mode`=1, core clock off, oscillator on, all four pin codes = 3) is entered two edges after reset release when, during reset, `ale_pin` was low with `psen_pin` high and `ale_pin` is still low at release. If `psen_pin` was low, or `ale_pin` was high at release, the block returns to run instead.
- R10: In emulation mode, `idle_req`, `pd_req` and `irq_pend` have no effect. Only a qualified reset ends the mode.
- R11: Pin codes: in run and reset all groups use code 0. In idle, ALE and PSEN use code 2. In power-down, ALE and PSEN use code 1. In idle or power-down, port 0 uses code 3 when `ext_exec`=1 and code 0 otherwise, and ports 1 to 3 use code 0.
- R12: `rst_pin` rising in idle restarts the core clock one edge later with `ram_wr_block`=1. `ram_wr_block` holds until `int_rst` rises and then drops. When `rst_pin` and `irq_pend` arrive in the same idle cycle, the reset path is taken.
- R13: While `rst_n` is low, `int_rst` is high. On the first edge after `rst_n` is released, the block enters run with all pin codes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Power-on reset, active low |
| rst_pin | input | 1 | External reset pin level, active high |
| ale_pin | input | 1 | Sensed level of the address-latch strobe pin |
| psen_pin | input | 1 | Sensed level of the program-read strobe pin |
| int0_n | input | 1 | External interrupt 0 pin, active low |
| int1_n | input | 1 | External interrupt 1 pin, active low |
| int0_en | input | 1 | Interrupt 0 enabled |
| int1_en | input | 1 | Interrupt 1 enabled |
| int0_level | input | 1 | Interrupt 0 set to level trigger |
| int1_level | input | 1 | Interrupt 1 set to level trigger |
| irq_pend | input | 1 | Some enabled interrupt is pending |
| idle_req | input | 1 | Software request for idle, one-cycle pulse |
| pd_req | input | 1 | Software request for power-down, one-cycle pulse |
| ext_exec | input | 1 | Code is being fetched from external memory |
| stable_cnt | input | STB_W | Oscillator settling count in clocks |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| int_rst | output | 1 | Internal reset |
| emu_mode | output | 1 | Emulation mode active |
| ram_wr_block | output | 1 | Blocks internal RAM writes |
| ale_ctl | output | 2 | ALE pin code |
| psen_ctl | output | 2 | PSEN pin code |
| p0_ctl | output | 2 | Port 0 code |
| px_ctl | output | 2 | Ports 1 to 3 code |

## Verification
Two pairs of events can arrive in the same cycle. The first pair is an idle request and a power-down request from software in one run cycle. The bench raises both together and expects the oscillator enable to drop, which shows that power-down won. The second pair is a reset-pin rise and a pending interrupt in one idle cycle. The bench drives both on the same edge and expects the core clock to restart with RAM writes blocked. It then expects the internal reset to follow K edges later, which rules out the plain interrupt wake.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_RUN     = 3'd1,
    ST_IDLE    = 3'd2,
    ST_IDLE_RX = 3'd3,
    ST_PD_STOP = 3'd4,
    ST_PD_WARM = 3'd5,
    ST_EMU     = 3'd6
  } pmc_state_e;

  typedef enum logic [1:0] {
    PIN_FUNC = 2'd0,
    PIN_LOW  = 2'd1,
    PIN_HIGH = 2'd2,
    PIN_REL  = 2'd3
  } pin_code_e;

  typedef struct packed {
    logic [1:0] ale;
    logic [1:0] psen;
    logic [1:0] p0;
    logic [1:0] px;
  } pin_sel_t;

endpackage

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
  parameter int CYC_PER_MC = 12,
  parameter int RST_MC     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin,
  input  logic osc_ok,
  output logic rst_q
);
  localparam int RST_CLKS = CYC_PER_MC * RST_MC;
  localparam int CW       = $clog2(RST_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          q_q, q_d;

  // count consecutive high samples, only while the oscillator is settled
  always_comb begin
    cnt_d = cnt_q;
    q_d   = q_q;
    if (!rst_pin) begin
      cnt_d = '0;
      q_d   = 1'b0;
    end else if (osc_ok && !q_q) begin
      if (cnt_q == LAST) q_d = 1'b1;
      else               cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      q_q   <= q_d;
    end
  end

  assign rst_q = q_q;
endmodule

// File: rtl/pmc_osc_wait.sv
module pmc_osc_wait #(
  parameter int STB_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic [STB_W-1:0] stable_cnt,
  output logic             osc_ok
);
  logic [STB_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!osc_en) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (!done_q) begin
      if (cnt_q >= stable_cnt) done_d = 1'b1;
      else                     cnt_d  = cnt_q + STB_W'(1);
    end
  end

  // oscillator is taken as running at power-on
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign osc_ok = osc_en && done_q;
endmodule

// File: rtl/pmc_pin_sel.sv
module pmc_pin_sel
  import pmc_pkg::*;
(
  input  pmc_state_e st,
  input  logic       ext_exec,
  output pin_sel_t   sel
);
  logic [1:0] p0_low_pwr;

  assign p0_low_pwr = ext_exec ? PIN_REL : PIN_FUNC;

  always_comb begin
    sel.ale  = PIN_FUNC;
    sel.psen = PIN_FUNC;
    sel.p0   = PIN_FUNC;
    sel.px   = PIN_FUNC;
    unique case (st)
      ST_IDLE: begin
        sel.ale  = PIN_HIGH;
        sel.psen = PIN_HIGH;
        sel.p0   = p0_low_pwr;
      end
      ST_PD_STOP, ST_PD_WARM: begin
        sel.ale  = PIN_LOW;
        sel.psen = PIN_LOW;
        sel.p0   = p0_low_pwr;
      end
      ST_EMU: begin
        sel.ale  = PIN_REL;
        sel.psen = PIN_REL;
        sel.p0   = PIN_REL;
        sel.px   = PIN_REL;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int CYC_PER_MC = 12,
  parameter int RST_MC     = 2,
  parameter int STB_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_pin,
  input  logic             ale_pin,
  input  logic             psen_pin,
  input  logic             int0_n,
  input  logic             int1_n,
  input  logic             int0_en,
  input  logic             int1_en,
  input  logic             int0_level,
  input  logic             int1_level,
  input  logic             irq_pend,
  input  logic             idle_req,
  input  logic             pd_req,
  input  logic             ext_exec,
  input  logic [STB_W-1:0] stable_cnt,
  output logic             core_clk_en,
  output logic             periph_clk_en,
  output logic             osc_en,
  output logic             int_rst,
  output logic             emu_mode,
  output logic             ram_wr_block,
  output logic [1:0]       ale_ctl,
  output logic [1:0]       psen_ctl,
  output logic [1:0]       p0_ctl,
  output logic [1:0]       px_ctl
);
  pmc_state_e st_q, st_d;
  logic       emu_arm_q, emu_arm_d;
  logic       rst_q, osc_ok, wake_low;
  pin_sel_t   sel;

  pmc_rst_qual #(.CYC_PER_MC(CYC_PER_MC), .RST_MC(RST_MC)) u_rq (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .osc_ok(osc_ok), .rst_q(rst_q)
  );

  pmc_osc_wait #(.STB_W(STB_W)) u_ow (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stable_cnt(stable_cnt), .osc_ok(osc_ok)
  );

  pmc_pin_sel u_ps (.st(st_q), .ext_exec(ext_exec), .sel(sel));

  // only an enabled, level-triggered external interrupt held low may wake
  assign wake_low = (int0_en && int0_level && !int0_n) ||
                    (int1_en && int1_level && !int1_n);

  always_comb begin
    st_d      = st_q;
    emu_arm_d = (st_q == ST_RESET) ? (!ale_pin && psen_pin) : 1'b0;
    if (rst_q && st_q != ST_RESET) begin
      st_d = ST_RESET;
    end else begin
      unique case (st_q)
        ST_RESET:   if (!rst_q) st_d = (emu_arm_q && !ale_pin) ? ST_EMU : ST_RUN;
        ST_RUN: begin
          if (pd_req)        st_d = ST_PD_STOP;
          else if (idle_req) st_d = ST_IDLE;
        end
        ST_IDLE: begin
          if (rst_pin)       st_d = ST_IDLE_RX;
          else if (irq_pend) st_d = ST_RUN;
        end
        ST_IDLE_RX: if (!rst_pin) st_d = ST_RUN;
        ST_PD_STOP: if (wake_low || rst_pin) st_d = ST_PD_WARM;
        ST_PD_WARM: if (osc_ok && !wake_low && !rst_pin) st_d = ST_RUN;
        ST_EMU:     st_d = ST_EMU;
        default:    st_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_RESET;
      emu_arm_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      emu_arm_q <= emu_arm_d;
    end
  end

  assign core_clk_en   = (st_q == ST_RESET) || (st_q == ST_RUN) || (st_q == ST_IDLE_RX);
  assign periph_clk_en = core_clk_en || (st_q == ST_IDLE);
  assign osc_en        = (st_q != ST_PD_STOP);
  assign int_rst       = (st_q == ST_RESET);
  assign emu_mode      = (st_q == ST_EMU);
  assign ram_wr_block  = (st_q == ST_IDLE_RX);
  assign ale_ctl       = sel.ale;
  assign psen_ctl      = sel.psen;
  assign p0_ctl        = sel.p0;
  assign px_ctl        = sel.px;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_pin,
  input logic       ale_pin,
  input logic       pd_req,
  input logic       osc_en,
  input logic       core_clk_en,
  input logic       periph_clk_en,
  input logic       int_rst,
  input logic       emu_mode,
  input logic       ram_wr_block,
  input logic [1:0] ale_ctl,
  input logic [1:0] psen_ctl
);
  p_rst_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_rst) |-> $past(rst_pin));

  p_osc_off_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> $past(pd_req));

  p_emu_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(emu_mode) |-> $past(int_rst && !ale_pin));

  p_emu_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    emu_mode |=> (emu_mode || int_rst));

  p_pd_pins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (ale_ctl == 2'd1 && psen_ctl == 2'd1));

  p_wrblk_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_wr_block) |-> $past(periph_clk_en && !core_clk_en && rst_pin));
endmodule

bind pwr_mode_ctrl pmc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .ale_pin(ale_pin), .pd_req(pd_req),
  .osc_en(osc_en), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
  .int_rst(int_rst), .emu_mode(emu_mode), .ram_wr_block(ram_wr_block),
  .ale_ctl(ale_ctl), .psen_ctl(psen_ctl)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/100ps
module sim_pwr_mode_ctrl;
  localparam int K = 24;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n, rst_pin, ale_pin, psen_pin, int0_n, int1_n;
  logic int0_en, int1_en, int0_level, int1_level, irq_pend, idle_req, pd_req, ext_exec;
  logic [7:0] stable_cnt;
  logic core_clk_en, periph_clk_en, osc_en, int_rst, emu_mode, ram_wr_block;
  logic [1:0] ale_ctl, psen_ctl, p0_ctl, px_ctl;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .ale_pin(ale_pin), .psen_pin(psen_pin),
    .int0_n(int0_n), .int1_n(int1_n), .int0_en(int0_en), .int1_en(int1_en),
    .int0_level(int0_level), .int1_level(int1_level), .irq_pend(irq_pend),
    .idle_req(idle_req), .pd_req(pd_req), .ext_exec(ext_exec), .stable_cnt(stable_cnt),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .int_rst(int_rst), .emu_mode(emu_mode), .ram_wr_block(ram_wr_block),
    .ale_ctl(ale_ctl), .psen_ctl(psen_ctl), .p0_ctl(p0_ctl), .px_ctl(px_ctl)
  );

  // {ext[11], mode[10:9] 0 run/1 idle/2 pd, ale[8:7], psen[6:5], p0[4:3], core, periph, osc}
  localparam logic [11:0] VEC [6] = '{
    12'b0_00_00_00_00_1_1_1,
    12'b0_01_10_10_00_0_1_1,
    12'b0_10_01_01_00_0_0_0,
    12'b1_00_00_00_00_1_1_1,
    12'b1_01_10_10_11_0_1_1,
    12'b1_10_01_01_11_0_0_0
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic pulse_pd();
    pd_req = 1'b1; tick(1); pd_req = 1'b0;
  endtask

  task automatic wake_int1();
    int1_en = 1'b1; int1_level = 1'b1; int1_n = 1'b0; tick(1);
    int1_n = 1'b1; tick(N + 2);
    int1_en = 1'b0; int1_level = 1'b0;
  endtask

  task automatic do_reset(input logic ale_rel);
    rst_pin = 1'b1; tick(K + 1);
    ale_pin = ale_rel; rst_pin = 1'b0; tick(2);
  endtask

  initial begin
    #(5.0 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rst_pin = 1'b0; ale_pin = 1'b1; psen_pin = 1'b1;
    int0_n = 1'b1; int1_n = 1'b1; int0_en = 1'b0; int1_en = 1'b0;
    int0_level = 1'b0; int1_level = 1'b0; irq_pend = 1'b0;
    idle_req = 1'b0; pd_req = 1'b0; ext_exec = 1'b0; stable_cnt = 8'(N);
    tick(3);
    chk("R13 int_rst during power-on", int'(int_rst), 1);
    rst_n = 1'b1; tick(1);
    chk("R13 core clock after power-on", int'(core_clk_en), 1);
    chk("R13 int_rst after power-on", int'(int_rst), 0);
    chk("R13 osc after power-on", int'(osc_en), 1);
    chk("R13 pins after power-on", int'({ale_ctl, psen_ctl, p0_ctl, px_ctl}), 0);

    // table walk over mode x external-execution
    for (int i = 0; i < 6; i++) begin
      logic [11:0] v;
      v = VEC[i];
      ext_exec = v[11];
      if (v[10:9] == 2'd1) begin idle_req = 1'b1; tick(1); idle_req = 1'b0; end
      if (v[10:9] == 2'd2) pulse_pd();
      chk("R11 ale code", int'(ale_ctl), int'(v[8:7]));
      chk("R11 psen code", int'(psen_ctl), int'(v[6:5]));
      chk("R11 port0 code", int'(p0_ctl), int'(v[4:3]));
      chk("R11 ports1-3 code", int'(px_ctl), 0);
      chk("R3/R4 core clock", int'(core_clk_en), int'(v[2]));
      chk("R3/R4 peripheral clock", int'(periph_clk_en), int'(v[1]));
      chk("R3/R4 oscillator", int'(osc_en), int'(v[0]));
      if (v[10:9] == 2'd1) begin
        irq_pend = 1'b1; tick(1); irq_pend = 1'b0;
        chk("R3 interrupt leaves idle", int'(core_clk_en), 1);
      end
      if (v[10:9] == 2'd2) begin
        wake_int1();
        chk("R6 wake back to run", int'(core_clk_en), 1);
      end
    end
    ext_exec = 1'b0;

    // R6 exact wake timing
    pulse_pd();
    int1_en = 1'b1; int1_level = 1'b1; int1_n = 1'b0; tick(1);
    int1_n = 1'b1;
    chk("R6 osc restarted", int'(osc_en), 1);
    tick(N + 1);
    chk("R6 core still off before settle", int'(core_clk_en), 0);
    tick(1);
    chk("R6 core on after settle", int'(core_clk_en), 1);
    int1_en = 1'b0; int1_level = 1'b0;

    // R7 pin held low past settle
    pulse_pd();
    int0_en = 1'b1; int0_level = 1'b1; int0_n = 1'b0; tick(1);
    tick(N + 5);
    chk("R7 core waits for pin high", int'(core_clk_en), 0);
    int0_n = 1'b1; tick(1);
    chk("R7 core on after pin high", int'(core_clk_en), 1);
    int0_en = 1'b0; int0_level = 1'b0;

    // R5 unqualified interrupt levels ignored
    pulse_pd();
    int0_en = 1'b1; int0_level = 1'b0; int0_n = 1'b0; tick(3);
    chk("R5 edge-mode pin ignored", int'(osc_en), 0);
    int0_en = 1'b0; int0_level = 1'b1; tick(3);
    chk("R5 disabled pin ignored", int'(osc_en), 0);
    int0_n = 1'b1; int0_level = 1'b0;
    wake_int1();

    // R4 idle and power-down in the same cycle
    idle_req = 1'b1; pd_req = 1'b1; tick(1); idle_req = 1'b0; pd_req = 1'b0;
    chk("R4 power-down wins over idle", int'(osc_en), 0);
    wake_int1();

    // R1 short pulse, then full qualification; R2 release
    rst_pin = 1'b1; tick(K - 1); rst_pin = 1'b0; tick(3);
    chk("R1 short pulse ignored", int'(int_rst), 0);
    rst_pin = 1'b1; tick(K);
    chk("R1 not yet reset", int'(int_rst), 0);
    tick(1);
    chk("R1 reset asserted", int'(int_rst), 1);
    rst_pin = 1'b0; tick(1);
    chk("R2 reset still held", int'(int_rst), 1);
    tick(1);
    chk("R2 reset released", int'(int_rst), 0);
    chk("R2 core running", int'(core_clk_en), 1);

    // R12 reset and interrupt together in idle
    idle_req = 1'b1; tick(1); idle_req = 1'b0;
    rst_pin = 1'b1; irq_pend = 1'b1; tick(1); irq_pend = 1'b0;
    chk("R12 core restarted", int'(core_clk_en), 1);
    chk("R12 ram writes blocked", int'(ram_wr_block), 1);
    tick(K - 1);
    chk("R12 block held before reset", int'(ram_wr_block), 1);
    chk("R12 no reset yet", int'(int_rst), 0);
    tick(1);
    chk("R12 reset took over", int'(int_rst), 1);
    chk("R12 block dropped", int'(ram_wr_block), 0);
    rst_pin = 1'b0; tick(2);

    // R8 reset from power-down
    pulse_pd();
    rst_pin = 1'b1; tick(1);
    chk("R8 osc restarted by reset pin", int'(osc_en), 1);
    tick(N + 1 + K);
    chk("R8 reset not yet", int'(int_rst), 0);
    tick(1);
    chk("R8 reset asserted", int'(int_rst), 1);
    rst_pin = 1'b0; tick(2);
    chk("R8 back to run", int'(core_clk_en), 1);

    // R9 emulation entry and R10 hold
    ale_pin = 1'b0; psen_pin = 1'b1;
    do_reset(1'b0);
    chk("R9 emulation entered", int'(emu_mode), 1);
    chk("R9 core off in emulation", int'(core_clk_en), 0);
    chk("R9 osc on in emulation", int'(osc_en), 1);
    chk("R9 pins released", int'({ale_ctl, psen_ctl, p0_ctl, px_ctl}), 8'hFF);
    idle_req = 1'b1; tick(1); idle_req = 1'b0;
    pd_req = 1'b1; tick(1); pd_req = 1'b0;
    irq_pend = 1'b1; tick(1); irq_pend = 1'b0;
    tick(1);
    chk("R10 emulation kept", int'(emu_mode), 1);
    chk("R10 osc kept", int'(osc_en), 1);
    rst_pin = 1'b1; tick(K + 1);
    chk("R10 reset ends emulation", int'(emu_mode), 0);
    chk("R10 reset asserted", int'(int_rst), 1);
    ale_pin = 1'b1; rst_pin = 1'b0; tick(2);
    chk("R9 ale high at release gives run", int'(emu_mode), 0);
    chk("R9 core runs", int'(core_clk_en), 1);

    // R9 psen low during reset
    ale_pin = 1'b0; psen_pin = 1'b0;
    do_reset(1'b0);
    chk("R9 psen low blocks emulation", int'(emu_mode), 0);
    chk("R9 psen low core runs", int'(core_clk_en), 1);
    ale_pin = 1'b1; psen_pin = 1'b1;

    finish_run();
  end
endmodule